// File: doc/BRIEF.md
# Interrupt Request Enable and Class Routing Registers

This block is the register front end of a 32-source interrupt controller. Each source has a hardware request line. Software can also raise any source by writing a software-request register. The two are ORed bit by bit into a raw request word. An enable mask gates that word, and a per-source class bit then steers every enabled, pending request to one of two outputs: a fast-interrupt line or a normal-interrupt line. Each output is the OR of all the requests steered to it. The block does no vectoring and no priority arbitration.

Software reaches the block over a simple synchronous register bus. A write takes effect on the clock edge where `bus_we` is high. Reads are combinational from `bus_addr`. The enable mask and the software-request word each have two write addresses, one that sets bits and one that clears them. Software can therefore turn single sources on or off without a read-modify-write sequence.

Top module: `intr_route_regs`

## Requirements
- R1: Offset 0x008 reads the raw request word, with bit n equal to `hw_req[n]` OR software-request bit n. Writes to 0x008 have no effect.
- R2: A write to offset 0x010 sets every enable bit whose written value is 1 and leaves bits written 0 unchanged. A read of 0x010 returns the enable mask.
- R3: A write to offset 0x014 clears every enable bit whose written value is 1 and leaves the rest unchanged. A read of 0x014 returns zero.
- R4: Offset 0x00C is the class-select register, read/write. Bit n = 1 routes source n to the fast line and bit n = 0 routes it to the normal line.
- R5: `fiq_o` is high exactly when some source n has raw bit n, enable bit n and select bit n all equal to 1. `irq_o` is high exactly when some source n has raw bit n and enable bit n equal to 1 and select bit n equal to 0.
- R6: A write to offset 0x018 sets software-request bits written 1. A write to offset 0x01C clears software-request bits written 1. A read of 0x018 returns the software-request word, and a read of 0x01C returns zero.
- R7: After reset the enable mask, the select register and the software-request word are all zero, so both outputs are low.
- R8: A read of any offset not listed in R1 to R6 returns zero. A write to such an offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | 12 | Byte offset of the register access |
| bus_we | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| hw_req | input | 32 | Hardware request lines, one per source, level sensitive |
| fiq_o | output | 1 | Fast-interrupt request |
| irq_o | output | 1 | Normal-interrupt request |

## Verification
The assertions assume that reset is released away from the clock edge and that `bus_addr`, `bus_we` and `bus_wdata` hold steady around each rising edge. The bench meets this by driving every bus and request input on the falling edge only. The assertions also assume that the request lines are levels and need no synchronisation, so the bench changes `hw_req` only between bus accesses. It sweeps every source against all four combinations of its enable and class bits. During each sweep the other 31 sources stay enabled with their requests low, which shows that the gating works per bit.

// File: rtl/intr_route_regs.sv
module intr_route_regs #(
  parameter int NSRC = 32,
  parameter int AW   = 12
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [AW-1:0]   bus_addr,
  input  logic            bus_we,
  input  logic [NSRC-1:0] bus_wdata,
  output logic [NSRC-1:0] bus_rdata,
  input  logic [NSRC-1:0] hw_req,
  output logic            fiq_o,
  output logic            irq_o
);

  localparam logic [AW-1:0] A_RAW    = AW'(8);
  localparam logic [AW-1:0] A_SEL    = AW'(12);
  localparam logic [AW-1:0] A_EN     = AW'(16);
  localparam logic [AW-1:0] A_ENCLR  = AW'(20);
  localparam logic [AW-1:0] A_SW     = AW'(24);
  localparam logic [AW-1:0] A_SWCLR  = AW'(28);
  localparam logic [NSRC-1:0] ZERO   = '0;

  logic [NSRC-1:0] en_q, sel_q, sw_q;
  logic [NSRC-1:0] en_set, en_clr, sw_set, sw_clr;
  logic [NSRC-1:0] raw, live;

  assign en_set = (bus_we && bus_addr == A_EN)    ? bus_wdata : ZERO;
  assign en_clr = (bus_we && bus_addr == A_ENCLR) ? bus_wdata : ZERO;
  assign sw_set = (bus_we && bus_addr == A_SW)    ? bus_wdata : ZERO;
  assign sw_clr = (bus_we && bus_addr == A_SWCLR) ? bus_wdata : ZERO;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= '0;
      sel_q <= '0;
      sw_q  <= '0;
    end else begin
      en_q <= (en_q | en_set) & ~en_clr;
      sw_q <= (sw_q | sw_set) & ~sw_clr;
      if (bus_we && bus_addr == A_SEL) sel_q <= bus_wdata;
    end
  end

  assign raw   = hw_req | sw_q;
  assign live  = raw & en_q;
  assign fiq_o = |(live & sel_q);
  assign irq_o = |(live & ~sel_q);

  always_comb begin
    case (bus_addr)
      A_RAW:   bus_rdata = raw;
      A_SEL:   bus_rdata = sel_q;
      A_EN:    bus_rdata = en_q;
      A_SW:    bus_rdata = sw_q;
      default: bus_rdata = '0;
    endcase
  end

  AST_EN_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_EN) |=> ((en_q & $past(bus_wdata)) == $past(bus_wdata))); // R2
  AST_EN_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_addr == A_ENCLR) |=> ((en_q & $past(bus_wdata)) == ZERO)); // R3
  AST_EN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && (bus_addr == A_EN || bus_addr == A_ENCLR)) |=> $stable(en_q)); // R8
  AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_we && bus_addr == A_SEL) |=> $stable(sel_q)); // R4
  AST_NO_EN_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == ZERO) |-> (!fiq_o && !irq_o)); // R5
  AST_ALL_FAST: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q == {NSRC{1'b1}}) |-> !irq_o); // R5
  AST_RESET_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (en_q == ZERO && sel_q == ZERO && sw_q == ZERO)); // R7
  AST_CLR_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_addr == A_ENCLR || bus_addr == A_SWCLR) |-> (bus_rdata == ZERO)); // R3

endmodule

// File: tb/intr_route_regs_bench.sv
module intr_route_regs_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] hw_req = '0;
  logic        fiq_o, irq_o;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  intr_route_regs u_intr_route_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .hw_req(hw_req),
    .fiq_o(fiq_o), .irq_o(irq_o));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b1; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic rdchk(input string req, input logic [11:0] a, input logic [31:0] exp);
    logic [31:0] v;
    rd(a, v);
    chk(req, v, exp);
  endtask

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    #2 rst_n = 1'b1;
    // R7 reset state
    rdchk("R7 enable", 12'h010, 32'h0);
    rdchk("R7 select", 12'h00C, 32'h0);
    rdchk("R7 swreq", 12'h018, 32'h0);
    rdchk("R7 raw", 12'h008, 32'h0);
    chk("R7 outputs", {30'd0, fiq_o, irq_o}, 32'h0);

    // R5 sweep every source against enable/select combinations
    for (int i = 0; i < 32; i++) begin
      for (int c = 0; c < 4; c++) begin
        logic e, s;
        logic [31:0] bit_i;
        e = c[0]; s = c[1];
        bit_i = 32'h1 << i;
        hw_req = '0;
        wr(12'h010, 32'hFFFF_FFFF);
        if (!e) wr(12'h014, bit_i);
        wr(12'h00C, s ? bit_i : ~bit_i);
        @(negedge clk); hw_req = bit_i;
        #1;
        chk("R5 fiq sweep", {31'd0, fiq_o}, {31'd0, e & s});
        chk("R5 irq sweep", {31'd0, irq_o}, {31'd0, e & ~s});
      end
    end
    hw_req = '0;

    // R4 select readback
    wr(12'h00C, 32'hA5A5_0F0F);
    rdchk("R4 select readback", 12'h00C, 32'hA5A5_0F0F);

    // R2 set-only behaviour
    wr(12'h014, 32'hFFFF_FFFF);
    rdchk("R3 clear all", 12'h010, 32'h0);
    wr(12'h010, 32'h0000_00F0);
    wr(12'h010, 32'h0F00_0000);
    rdchk("R2 accumulate", 12'h010, 32'h0F00_00F0);
    wr(12'h010, 32'h0);
    rdchk("R2 zero write", 12'h010, 32'h0F00_00F0);

    // R3 clear-only behaviour
    wr(12'h014, 32'h0000_0030);
    rdchk("R3 partial clear", 12'h010, 32'h0F00_00C0);
    rdchk("R3 clear reads zero", 12'h014, 32'h0);

    // R1 raw combine and write ignored
    hw_req = 32'h1234_0000;
    wr(12'h018, 32'h0000_5678);
    rdchk("R1 raw combine", 12'h008, 32'h1234_5678);
    wr(12'h008, 32'hFFFF_FFFF);
    rdchk("R1 raw write ignored", 12'h008, 32'h1234_5678);
    hw_req = '0;

    // R6 software request set/clear
    wr(12'h018, 32'h8000_0000);
    rdchk("R6 sw set", 12'h018, 32'h8000_5678);
    wr(12'h01C, 32'h0000_5678);
    rdchk("R6 sw clear", 12'h018, 32'h8000_0000);
    rdchk("R6 clear reads zero", 12'h01C, 32'h0);
    wr(12'h010, 32'h8000_0000);
    wr(12'h00C, 32'h0);
    @(negedge clk); #1;
    chk("R6 sw drives irq", {30'd0, fiq_o, irq_o}, 32'h1);
    wr(12'h00C, 32'h8000_0000);
    @(negedge clk); #1;
    chk("R6 sw drives fiq", {30'd0, fiq_o, irq_o}, 32'h2);
    wr(12'h01C, 32'hFFFF_FFFF);
    @(negedge clk); #1;
    chk("R6 sw cleared quiet", {30'd0, fiq_o, irq_o}, 32'h0);

    // R8 unmapped offsets
    wr(12'h00C, 32'h0000_0003);
    rd(12'h010, v);
    for (int k = 0; k < 6; k++) begin
      logic [11:0] a;
      a = (k == 0) ? 12'h000 : (k == 1) ? 12'h004 : (k == 2) ? 12'h011 :
          (k == 3) ? 12'h020 : (k == 4) ? 12'h100 : 12'hFFC;
      wr(a, 32'hFFFF_FFFF);
      rdchk("R8 unmapped read", a, 32'h0);
    end
    rdchk("R8 enable untouched", 12'h010, v);
    rdchk("R8 select untouched", 12'h00C, 32'h0000_0003);
    rdchk("R8 swreq untouched", 12'h018, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule